// File: doc/BRIEF.md
# Streaming Range Detector

This block watches a stream of 6-bit unsigned samples and reports the spread of the values it has taken in. The spread is the largest accepted sample minus the smallest accepted sample. A sample counts only in a clock cycle where the enable input is high. Cycles where the enable is low leave the result as it was.

A synchronous, active-high reset clears the result to zero and forgets every sample taken so far. The first sample after a reset sets both the running maximum and the running minimum, so the result stays zero until a second, different value arrives.

The result is a register. It shows a newly accepted sample right after the clock edge that took the sample in. Between two resets the result can only grow.

Top module: `range_span_detector`

## Requirements
- R1: When `rst` is 1 at a rising clock edge, `data_out` is 0 after that edge, and the maximum and minimum taken so far are forgotten.
- R2: When `rst` and `data_en` are both 1 at the same edge, the reset takes effect and the sample on `data_in` is discarded. The discarded value plays no part in any later `data_out`.
- R3: The first sample accepted after a reset loads both the maximum and the minimum, so `data_out` is 0 after that edge.
- R4: At an edge where `rst` is 0 and `data_en` is 0, `data_out` keeps its value and `data_in` is ignored.
- R5: After each edge where `rst` is 0 and `data_en` is 1, `data_out` equals the maximum minus the minimum of all samples accepted since the last reset, including the new one.
- R6: The samples 0 and 63 together give a `data_out` of 63, with no wrap or underflow.
- R7: Between resets, `data_out` never decreases.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset; wins over `data_en` |
| data_en | input | 1 | Accept the value on `data_in` at this edge |
| data_in | input | 6 | Unsigned sample |
| data_out | output | 6 | Registered maximum minus minimum since reset |

## Verification
Two functions can fall in the same cycle: the reset and the acceptance of a sample. The bench drives both high at once, using a value outside the range seen so far. It also does this at random points during the long random stream.

The check has two parts. First, `data_out` must read 0 after the edge with both inputs high. Second, the following samples must yield spreads that take no account of the discarded value. A mistake in the priority would therefore show up as a spread that is too wide.

// File: rtl/rng_pkg.sv
package rng_pkg;
    parameter int SAMPLE_W = 6;

    typedef logic [SAMPLE_W-1:0] sample_t;

    typedef struct packed {
        logic    seen;
        sample_t hi;
        sample_t lo;
    } extent_t;

    localparam extent_t EXTENT_EMPTY = '{seen: 1'b0, hi: '0, lo: '0};

    function automatic sample_t span_of(extent_t e);
        return e.seen ? sample_t'(e.hi - e.lo) : '0;
    endfunction

    function automatic extent_t absorb(extent_t e, sample_t s);
        extent_t r;
        if (!e.seen) begin
            r = '{seen: 1'b1, hi: s, lo: s};
        end else begin
            r.seen = 1'b1;
            r.hi   = (s > e.hi) ? s : e.hi;
            r.lo   = (s < e.lo) ? s : e.lo;
        end
        return r;
    endfunction
endpackage

// File: rtl/rng_extent_track.sv
module rng_extent_track
    import rng_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    take,
    input  sample_t sample,
    output extent_t nxt,
    output extent_t cur
);
    always_comb begin
        if (rst)       nxt = EXTENT_EMPTY;
        else if (take) nxt = absorb(cur, sample);
        else           nxt = cur;
    end

    always_ff @(posedge clk) begin
        cur <= nxt;
    end

    AST_ORDERED: assert property (@(posedge clk) disable iff (rst)
        cur.seen |-> (cur.hi >= cur.lo)) else $error("hi below lo"); // R5

    AST_FIRST_LOADS_BOTH: assert property (@(posedge clk) disable iff (rst)
        ($past(take) && !$past(rst) && !$past(cur.seen)) |-> (cur.seen && cur.hi == cur.lo))
        else $error("first sample did not load both"); // R3
endmodule

// File: rtl/rng_span_reg.sv
module rng_span_reg
    import rng_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    load,
    input  extent_t src,
    output sample_t span
);
    always_ff @(posedge clk) begin
        if (rst)       span <= '0;
        else if (load) span <= span_of(src);
    end
endmodule

// File: rtl/range_span_detector.sv
module range_span_detector
    import rng_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                data_en,
    input  logic [SAMPLE_W-1:0] data_in,
    output logic [SAMPLE_W-1:0] data_out
);
    extent_t ext_nxt;
    extent_t ext_cur;

    rng_extent_track u_track (
        .clk    (clk),
        .rst    (rst),
        .take   (data_en),
        .sample (data_in),
        .nxt    (ext_nxt),
        .cur    (ext_cur)
    );

    rng_span_reg u_span (
        .clk  (clk),
        .rst  (rst),
        .load (data_en),
        .src  (ext_nxt),
        .span (data_out)
    );

    AST_RST_CLEARS: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (data_out == '0)) else $error("reset did not clear"); // R1

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(data_en)) |-> (data_out == $past(data_out)))
        else $error("output moved while idle"); // R4

    AST_NEVER_SHRINKS: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (data_out >= $past(data_out))) else $error("spread shrank"); // R7
endmodule

// File: tb/tb_range_span_detector.sv
`timescale 1ns/1ps
module tb_range_span_detector;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       data_en = 1'b0;
    logic [5:0] data_in = '0;
    logic [5:0] data_out;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    bit       m_seen = 1'b0;
    int       m_hi = 0;
    int       m_lo = 0;
    int       m_out = 0;

    always #2.5 clk = ~clk;

    range_span_detector dut (
        .clk(clk), .rst(rst), .data_en(data_en), .data_in(data_in), .data_out(data_out)
    );

    function automatic void model_step(bit r, bit e, int d);
        if (r) begin
            m_seen = 1'b0; m_hi = 0; m_lo = 0; m_out = 0;
        end else if (e) begin
            if (!m_seen) begin
                m_seen = 1'b1; m_hi = d; m_lo = d;
            end else begin
                if (d > m_hi) m_hi = d;
                if (d < m_lo) m_lo = d;
            end
            m_out = m_hi - m_lo;
        end
    endfunction

    task automatic check(string tag);
        total++;
        if (data_out !== 6'(m_out)) begin
            bad++;
            $display("FAIL %s: data_out=%0d expected=%0d", tag, data_out, m_out);
        end
    endtask

    task automatic step(bit r, bit e, int d, string tag);
        @(negedge clk);
        rst = r; data_en = e; data_in = 6'(d);
        @(posedge clk);
        #1;
        model_step(r, e, d);
        check(tag);
    endtask

    initial begin
        #200000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: data_out=%0d expected=finish", data_out);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (2) @(posedge clk);
        step(1, 0, 0, "R1 reset state");
        step(0, 1, 20, "R3 first sample");
        step(0, 0, 63, "R4 idle ignores data_in");
        step(0, 1, 30, "R5 second sample");
        step(0, 1, 10, "R5 new minimum");
        step(0, 1, 25, "R7 inner sample keeps spread");
        step(0, 0, 0, "R4 idle hold");
        step(1, 1, 63, "R2 reset with enable");
        step(0, 1, 40, "R2 first after discard");
        step(0, 1, 45, "R2 discarded value absent");
        step(1, 0, 0, "R1 reset clears");
        step(0, 1, 0, "R6 zero sample");
        step(0, 1, 63, "R6 full span");
        step(0, 1, 31, "R7 no shrink at full span");
        step(1, 0, 0, "R1 reset again");
        step(0, 1, 63, "R3 first sample at top");
        for (int i = 0; i < 3000; i++) begin
            int  rv;
            bit  r;
            bit  e;
            rv = $urandom_range(0, 99);
            r  = (rv < 3);
            e  = ($urandom_range(0, 99) < 60);
            if (r && e) step(r, e, $urandom_range(0, 63), "R2 random reset with enable");
            else if (r) step(r, e, $urandom_range(0, 63), "R1 random reset");
            else if (e) step(r, e, $urandom_range(0, 63), "R5 random sample");
            else        step(r, e, $urandom_range(0, 63), "R4 random idle");
        end
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule